// File: doc/BRIEF.md
# Pulse-Pause Frame Encoder

This block is the transmit side of a contactless reader. It sends a data word of up to 16 bits by switching a carrier-enable output. Each bit opens with a carrier-off gap of fixed length. The carrier then comes back on, and the length of that on-time sets the bit's total period: a long period means 1 and a short period means 0. Bits go out least significant first. One more gap follows the last bit and closes the frame. After that gap the carrier stays on, so the tag keeps its power.

Time is counted only on cycles where the tick-enable input is high. In the intended system that tick is the system clock divided by 32. The user gives a start pulse together with a data word and a bit count. The block copies both into its own registers, holds `busy` high for the whole frame, and pulses `done` for one cycle when the closing gap ends. In that same cycle it clears a free-running tick counter. A downstream receiver reads this counter to measure how long the tag takes to reply.

Top module: `ppe_frame_tx`

## Requirements
- R1: While reset is asserted, and whenever the block is idle, `carrier_on` is 1. During reset `busy` is 0, `done` is 0 and `ref_timer` is 0.
- R2: The bits of the latched word are sent least significant bit first.
- R3: Every data bit begins with a carrier-off gap of exactly 30 ticks.
- R4: The total bit period is 150 ticks for a 1 and 90 ticks for a 0. The carrier is therefore on for 120 ticks after the gap for a 1, and for 60 ticks for a 0.
- R5: After the last data bit the block sends one more 30-tick carrier-off gap and then turns the carrier back on. In the cycle the carrier comes back on, `busy` falls and `done` is 1; `done` is high for that single cycle only.
- R6: `ref_timer` is 0 in the cycle where `done` is 1. It then increases by one for each tick and stops at its maximum value, which is all ones.
- R7: A start with a bit count of 0 sends only the 30-tick closing gap.
- R8: A bit count from 17 to 31 is treated as 16.
- R9: While `busy` is 1, a start pulse is ignored. The frame in progress continues unchanged.
- R10: The data word and the bit count are captured on the accepted start. Changes at `data_in` or `nbits_in` during a frame have no effect on that frame.
- R11: Gap lengths, bit periods and the timer advance only on cycles where `tick_en` is 1. The spacing between ticks does not change any length measured in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle timing tick |
| start | input | 1 | Request to send a frame; only accepted while idle |
| data_in | input | 16 | Word to send, least significant bit first |
| nbits_in | input | 5 | Number of bits to send (0 to 16; larger values are clamped to 16) |
| carrier_on | output | 1 | Carrier enable: 1 = carrier on |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-cycle pulse when the frame is finished |
| ref_timer | output | 16 | Ticks counted since the last frame ended; stops at all ones |

## Verification
A scoreboard compares every carrier-off and carrier-on run, measured in ticks, against the runs the bench predicts.

- A two-bit word 0x0001 gives a long bit followed by a short bit. The reverse order would show that the bits go out in the wrong order.
- A mixed 16-bit word checks both period lengths many times in a row.
- A zero bit count and an oversized bit count check the empty frame and the clamp to 16.
- A frame where the inputs are scrambled and a second start is pulsed halfway through checks the capture on start and the ignored start. Either fault would change the sequence of runs.
- One frame is sent with a tick on every third cycle, which separates tick counting from clock counting.
- The reference timer is checked right after each `done`, and again after a long idle wait to confirm it stops at all ones.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP   = 2'd1,
        ST_MARK  = 2'd2,
        ST_CLOSE = 2'd3
    } ppe_state_e;

endpackage

// File: rtl/ppe_period_sel.sv
module ppe_period_sel #(
    parameter int TICK_W      = 8,
    parameter int GAP_TICKS   = 30,
    parameter int LONG_TICKS  = 150,
    parameter int SHORT_TICKS = 90
) (
    input  logic              bit_val,
    output logic [TICK_W-1:0] gap_last,
    output logic [TICK_W-1:0] period_last
);
    localparam logic [TICK_W-1:0] GAP_LAST_C   = TICK_W'(GAP_TICKS - 1);
    localparam logic [TICK_W-1:0] LONG_LAST_C  = TICK_W'(LONG_TICKS - 1);
    localparam logic [TICK_W-1:0] SHORT_LAST_C = TICK_W'(SHORT_TICKS - 1);

    // Last tick index of the gap and of the whole bit period.
    always_comb begin
        gap_last    = GAP_LAST_C;
        period_last = bit_val ? LONG_LAST_C : SHORT_LAST_C;
    end

endmodule

// File: rtl/ppe_bit_shifter.sv
module ppe_bit_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             lsb
);
    logic [WIDTH-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load) begin
            word_d = din;
        end else if (shift) begin
            word_d = {1'b0, word_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign lsb = word_q[0];

endmodule

// File: rtl/ppe_ref_timer.sv
module ppe_ref_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] TOP_C = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != TOP_C)) begin
            cnt_d = cnt_q + WIDTH'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value = cnt_q;

endmodule

// File: rtl/ppe_frame_tx.sv
module ppe_frame_tx #(
    parameter int MAX_BITS    = 16,
    parameter int GAP_TICKS   = 30,
    parameter int LONG_TICKS  = 150,
    parameter int SHORT_TICKS = 90,
    parameter int TIMER_W     = 16,
    localparam int CNT_W      = $clog2(MAX_BITS + 1),
    localparam int TICK_W     = $clog2(LONG_TICKS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                start,
    input  logic [MAX_BITS-1:0] data_in,
    input  logic [CNT_W-1:0]    nbits_in,
    output logic                carrier_on,
    output logic                busy,
    output logic                done,
    output logic [TIMER_W-1:0]  ref_timer
);
    import ppe_pkg::*;

    typedef struct packed {
        ppe_state_e        st;
        logic [CNT_W-1:0]  left;
        logic [TICK_W-1:0] tcnt;
        logic              carrier;
        logic              busy;
        logic              done;
    } ctrl_t;

    localparam logic [CNT_W-1:0] MAX_CNT_C = CNT_W'(MAX_BITS);

    ctrl_t             ctrl_d, ctrl_q;
    logic              load_word, shift_word, clear_timer;
    logic              cur_bit;
    logic [TICK_W-1:0] gap_last, period_last;
    logic [CNT_W-1:0]  clamped_cnt;

    ppe_bit_shifter #(.WIDTH(MAX_BITS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_word),
        .shift (shift_word),
        .din   (data_in),
        .lsb   (cur_bit)
    );

    ppe_period_sel #(
        .TICK_W      (TICK_W),
        .GAP_TICKS   (GAP_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_period (
        .bit_val     (cur_bit),
        .gap_last    (gap_last),
        .period_last (period_last)
    );

    ppe_ref_timer #(.WIDTH(TIMER_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_timer),
        .tick  (tick_en),
        .value (ref_timer)
    );

    assign clamped_cnt = (nbits_in > MAX_CNT_C) ? MAX_CNT_C : nbits_in;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        load_word   = 1'b0;
        shift_word  = 1'b0;
        clear_timer = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                ctrl_d.carrier = 1'b1;
                ctrl_d.busy    = 1'b0;
                if (start) begin
                    load_word      = 1'b1;
                    ctrl_d.left    = clamped_cnt;
                    ctrl_d.tcnt    = '0;
                    ctrl_d.busy    = 1'b1;
                    ctrl_d.carrier = 1'b0;
                    ctrl_d.st      = (clamped_cnt == '0) ? ST_CLOSE : ST_GAP;
                end
            end
            ST_GAP: begin
                if (tick_en) begin
                    ctrl_d.tcnt = ctrl_q.tcnt + TICK_W'(1);
                    if (ctrl_q.tcnt == gap_last) begin
                        ctrl_d.carrier = 1'b1;
                        ctrl_d.st      = ST_MARK;
                    end
                end
            end
            ST_MARK: begin
                if (tick_en) begin
                    if (ctrl_q.tcnt == period_last) begin
                        shift_word     = 1'b1;
                        ctrl_d.tcnt    = '0;
                        ctrl_d.carrier = 1'b0;
                        ctrl_d.left    = ctrl_q.left - CNT_W'(1);
                        ctrl_d.st      = (ctrl_q.left == CNT_W'(1)) ? ST_CLOSE : ST_GAP;
                    end else begin
                        ctrl_d.tcnt = ctrl_q.tcnt + TICK_W'(1);
                    end
                end
            end
            ST_CLOSE: begin
                if (tick_en) begin
                    if (ctrl_q.tcnt == gap_last) begin
                        clear_timer    = 1'b1;
                        ctrl_d.tcnt    = '0;
                        ctrl_d.carrier = 1'b1;
                        ctrl_d.busy    = 1'b0;
                        ctrl_d.done    = 1'b1;
                        ctrl_d.st      = ST_IDLE;
                    end else begin
                        ctrl_d.tcnt = ctrl_q.tcnt + TICK_W'(1);
                    end
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st      <= ST_IDLE;
            ctrl_q.left    <= '0;
            ctrl_q.tcnt    <= '0;
            ctrl_q.carrier <= 1'b1;
            ctrl_q.busy    <= 1'b0;
            ctrl_q.done    <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign carrier_on = ctrl_q.carrier;
    assign busy       = ctrl_q.busy;
    assign done       = ctrl_q.done;

endmodule

// File: rtl/ppe_frame_tx_chk.sv
module ppe_frame_tx_chk #(
    parameter int GAP_TICKS = 30,
    parameter int TIMER_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic               start,
    input logic               carrier_on,
    input logic               busy,
    input logic               done,
    input logic [TIMER_W-1:0] ref_timer
);
    // Ticks counted while the carrier is off.
    logic [15:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
        end else if (!carrier_on) begin
            lo_cnt <= lo_cnt + 16'(tick_en);
        end else begin
            lo_cnt <= '0;
        end
    end

    AST_IDLE_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> carrier_on); // R1
    AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_on) |-> (lo_cnt == 16'(GAP_TICKS))); // R3
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && carrier_on)); // R5
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R5
    AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ref_timer == '0)); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done)); // R9
    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(ref_timer)); // R11

endmodule

bind ppe_frame_tx ppe_frame_tx_chk #(
    .GAP_TICKS (GAP_TICKS),
    .TIMER_W   (TIMER_W)
) u_chk (.*);

// File: tb/ppe_frame_tx_test.sv
`timescale 1ns/1ps
module ppe_frame_tx_test;
    localparam int GAP = 30;
    localparam int LNG = 150;
    localparam int SHT = 90;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        start = 1'b0;
    logic [15:0] data_in = '0;
    logic [4:0]  nbits_in = '0;
    logic        carrier_on, busy, done;
    logic [15:0] ref_timer;

    int n_chk = 0;
    int n_fail = 0;
    int tick_per = 1;
    int phase = 0;
    int exp_q[$];
    string cur_req = "R1";

    always #2 clk = ~clk;

    ppe_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
        .data_in(data_in), .nbits_in(nbits_in), .carrier_on(carrier_on),
        .busy(busy), .done(done), .ref_timer(ref_timer)
    );

    // Tick generator: changes 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        tick_en = (phase == 0);
        phase = (phase + 1 >= tick_per) ? 0 : phase + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: measure carrier runs in ticks and compare with the queue.
    // A positive entry is an off run, a negative entry is an on run inside a frame.
    logic prev_c = 1'b1;
    bit   hi_valid = 1'b0;
    int   lo_run = 0;
    int   hi_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (carrier_on != prev_c) begin
                if (!prev_c) begin
                    if (exp_q.size() == 0 || exp_q[0] <= 0) begin
                        check(1'b0, cur_req, "R3 unexpected off run", lo_run, 0);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        check(lo_run == e, cur_req, "R3 off run ticks", lo_run, e);
                    end
                    hi_valid = busy;
                end else if (hi_valid) begin
                    if (exp_q.size() == 0 || exp_q[0] >= 0) begin
                        check(1'b0, cur_req, "R4 unexpected on run", hi_run, 0);
                    end else begin
                        int e;
                        e = -exp_q.pop_front();
                        check(hi_run == e, cur_req, "R4 on run ticks", hi_run, e);
                    end
                end
                lo_run = 0;
                hi_run = 0;
            end
            if (!carrier_on) lo_run += int'(tick_en);
            else             hi_run += int'(tick_en);
            prev_c = carrier_on;
        end
    end

    // Driver: push the expected runs, start the frame, then check the end of the frame.
    task automatic send_frame(input logic [15:0] d, input int n,
                              input string req, input bit disturb);
        int eff;
        int guard;
        int seen;
        eff = (n > 16) ? 16 : n;
        cur_req = req;
        for (int i = 0; i < eff; i++) begin
            exp_q.push_back(GAP);
            exp_q.push_back(-((d[i] ? LNG : SHT) - GAP));
        end
        exp_q.push_back(GAP);
        @(negedge clk);
        data_in  = d;
        nbits_in = 5'(n);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, req, "busy after start", int'(busy), 1);
        if (disturb) begin
            data_in  = ~d;
            nbits_in = 5'd3;
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R9", "busy after ignored start", int'(busy), 1);
            data_in = 16'h1234;
        end
        guard = 0;
        while (!done && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R5", "done seen", int'(done), 1);
        check(busy == 1'b0, "R5", "busy low with done", int'(busy), 0);
        check(carrier_on == 1'b1, "R5", "carrier on with done", int'(carrier_on), 1);
        check(ref_timer == 16'd0, "R6", "timer cleared at done", int'(ref_timer), 0);
        seen = int'(tick_en);
        @(negedge clk);
        check(done == 1'b0, "R5", "done lasts one cycle", int'(done), 0);
        check(exp_q.size() == 0, req, "all runs seen", exp_q.size(), 0);
        for (int k = 0; k < 9; k++) begin
            seen += int'(tick_en);
            @(negedge clk);
        end
        check(int'(ref_timer) == seen, "R6", "timer counts ticks", int'(ref_timer), seen);
    endtask

    initial begin
        #760000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is asserted
        check(carrier_on == 1'b1, "R1", "carrier in reset", int'(carrier_on), 1);
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(ref_timer == 16'd0, "R1", "timer in reset", int'(ref_timer), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(carrier_on == 1'b1, "R1", "carrier idle", int'(carrier_on), 1);

        // R2: a long bit then a short bit; the reverse order would mean MSB first
        send_frame(16'h0001, 2, "R2", 1'b0);
        // R4: mixed word, both periods
        send_frame(16'hA5C3, 16, "R4", 1'b0);
        // R7: zero bit count gives only the closing gap
        send_frame(16'hFFFF, 0, "R7", 1'b0);
        // R8: bit count 20 is clamped to 16
        send_frame(16'h00FF, 20, "R8", 1'b0);
        // R9 and R10: scrambled inputs and a second start during the frame
        send_frame(16'h0F0F, 8, "R10", 1'b1);
        // R11: a tick every third cycle
        tick_per = 3;
        send_frame(16'h0035, 7, "R11", 1'b0);
        tick_per = 1;
        // R6: the timer stops at all ones
        repeat (65600) @(negedge clk);
        check(ref_timer == 16'hFFFF, "R6", "timer saturates", int'(ref_timer), 65535);
        check(carrier_on == 1'b1, "R1", "carrier idle after frames", int'(carrier_on), 1);
        finish_run();
    end

endmodule